// File: doc/BRIEF.md
# Delay-Slot PC Sequencer

This block owns the program-counter pair of a 32-bit core that has exactly one branch delay slot. It keeps the address of the instruction that executes now (`pc_q`) and the address that executes after it (`npc_q`). Each accepted step moves the pair forward by one instruction. On a control transfer, the pair hands the old next address to the current PC and loads the target only into the next PC. The instruction after a branch or jump therefore always runs before the target is reached.

The surrounding core decodes and reads its operands elsewhere. Each step it presents the major opcode, the raw instruction word, the two operand values that were already read, a strobe, and a flag saying whether the instruction may transfer control. The block evaluates the conditional-branch tests and forms relative, region-absolute and register targets. It reports a link-register write (index and return address) one cycle later. A branch or jump found inside a delay slot raises a sticky fault and freezes the pair.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `pc_q`=0, `npc_q`=4, `fault`=0 and `link_we`=0.
- R2: At an edge where `step_valid` is low, `pc_q`, `npc_q`, `fault`, `link_idx` and `link_val` keep their values, and `link_we` is 0 after that edge.
- R3: A step that is not a control transfer sets `pc_q` to the old `npc_q` and `npc_q` to the old `npc_q`+4.
- R4: A control-transfer step outside a delay slot sets `pc_q` to the old `npc_q`. It sets `npc_q` to the target when the transfer is taken, and to the old `npc_q`+4 when it is not taken.
- R5: Branch conditions use the opcode in `opcode`. Opcode 4 is taken when rs equals rt, and opcode 5 when they differ. Opcode 6 is taken when rs (signed) is at most 0, and opcode 7 when rs is above 0. Opcode 1 reads `instr[20:16]` as a sub-code: 0 is taken when rs < 0 and 1 when rs >= 0 (signed). Any other sub-code is never taken.
- R6: A taken branch target is old `pc_q` + 4 + (sign-extended `instr[15:0]` shifted left by 2).
- R7: Opcodes 2 and 3 always transfer to {old `npc_q`[31:28], `instr[25:0]`, 2'b00}.
- R8: Opcode 0 with `instr[5:0]` equal to 8 or 9 always transfers to the full rs value.
- R9: Opcode 3 links to register 31, and opcode 0 with function 9 links to register `instr[15:11]`. The link value is old `pc_q`+8. The link is shown by `link_we`=1 for the single cycle after the step. Opcode 2, function 8 and the conditional branches never link.
- R10: A link whose register index is 0 leaves `link_we` at 0.
- R11: A control-transfer step taken when `npc_q` differs from `pc_q`+4 sets `fault`. That step leaves `pc_q` and `npc_q` unchanged and makes no link.
- R12: Once `fault` is 1, it stays 1 until reset. All later steps leave `pc_q` and `npc_q` unchanged and make no link.
- R13: A step with `is_ctrl`=0, or with `is_ctrl`=1 and an opcode/function that is none of the above, is handled as in R3 and never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Accept one instruction step this cycle |
| is_ctrl | input | 1 | Instruction may transfer control; 0 forces sequential |
| opcode | input | 6 | Major opcode of the instruction |
| instr | input | 32 | Full instruction word |
| rs_val | input | 32 | First operand value |
| rt_val | input | 32 | Second operand value |
| pc_q | output | 32 | Address of the instruction executing now |
| npc_q | output | 32 | Address of the following instruction |
| fault | output | 1 | Sticky delay-slot control-transfer fault |
| link_we | output | 1 | Link write strobe, one cycle after the step |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Return address to write |

## Verification
A wrong PC pair is visible at the ports one cycle after the step that caused it. Every later step carries the error forward: the next `pc_q` repeats the bad `npc_q`, and the next relative target is formed from the bad `pc_q`. A delay-slot decision that is wrong in either direction is just as quick to show. It appears as a `fault` rising one edge after the offending step, or as a pair that moves when it should freeze. A wrong link register, or a lost link pulse, appears on the link port in that same following cycle.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OPC_REGIMM  = 6'd1;
    localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JMPLNK  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BREQ    = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BRNE    = 6'd5;
    localparam logic [OPC_W-1:0] OPC_BRLEZ   = 6'd6;
    localparam logic [OPC_W-1:0] OPC_BRGTZ   = 6'd7;

    localparam logic [5:0] FN_JREG    = 6'd8;
    localparam logic [5:0] FN_JREGLNK = 6'd9;

    localparam logic [REG_W-1:0] SUB_LTZ = 5'd0;
    localparam logic [REG_W-1:0] SUB_GEZ = 5'd1;

    typedef enum logic [1:0] {
        XF_NONE,
        XF_BRANCH,
        XF_REGION,
        XF_REG
    } xfer_kind_e;

    typedef enum logic [2:0] {
        CC_EQ,
        CC_NE,
        CC_LEZ,
        CC_GTZ,
        CC_LTZ,
        CC_GEZ,
        CC_NEVER
    } cond_e;

    typedef struct packed {
        xfer_kind_e       kind;
        cond_e            cond;
        logic             link;
        logic [REG_W-1:0] link_idx;
    } xfer_dec_t;

    function automatic logic [WORD_W-1:0] branch_offset(input logic [15:0] imm);
        return {{(WORD_W-18){imm[15]}}, imm, 2'b00};
    endfunction

    function automatic logic cond_met(input cond_e cc,
                                      input logic [WORD_W-1:0] a,
                                      input logic [WORD_W-1:0] b);
        logic sgn, zer;
        sgn = a[WORD_W-1];
        zer = (a == '0);
        case (cc)
            CC_EQ:   return a == b;
            CC_NE:   return a != b;
            CC_LEZ:  return sgn | zer;
            CC_GTZ:  return ~sgn & ~zer;
            CC_LTZ:  return sgn;
            CC_GEZ:  return ~sgn;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dslot_decode.sv
module dslot_decode
    import dslot_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic                is_ctrl,
    input  logic [OPC_W-1:0]    opcode,
    input  logic [WORD_W-1:0]   instr,
    output xfer_dec_t           dec
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    logic [5:0]       funct;
    logic [REG_W-1:0] rt_field;
    logic [REG_W-1:0] rd_field;

    assign funct    = instr[5:0];
    assign rt_field = instr[20:16];
    assign rd_field = instr[15:11];

    always_comb begin
        dec.kind     = XF_NONE;
        dec.cond     = CC_NEVER;
        dec.link     = 1'b0;
        dec.link_idx = '0;
        if (is_ctrl) begin
            case (opcode)
                OPC_JMP: dec.kind = XF_REGION;
                OPC_JMPLNK: begin
                    dec.kind     = XF_REGION;
                    dec.link     = 1'b1;
                    dec.link_idx = LINK_IDX;
                end
                OPC_SPECIAL: begin
                    if (funct == FN_JREG) begin
                        dec.kind = XF_REG;
                    end else if (funct == FN_JREGLNK) begin
                        dec.kind     = XF_REG;
                        dec.link     = 1'b1;
                        dec.link_idx = rd_field;
                    end
                end
                OPC_BREQ: begin
                    dec.kind = XF_BRANCH;
                    dec.cond = CC_EQ;
                end
                OPC_BRNE: begin
                    dec.kind = XF_BRANCH;
                    dec.cond = CC_NE;
                end
                OPC_BRLEZ: begin
                    dec.kind = XF_BRANCH;
                    dec.cond = CC_LEZ;
                end
                OPC_BRGTZ: begin
                    dec.kind = XF_BRANCH;
                    dec.cond = CC_GTZ;
                end
                OPC_REGIMM: begin
                    dec.kind = XF_BRANCH;
                    if (rt_field == SUB_LTZ)      dec.cond = CC_LTZ;
                    else if (rt_field == SUB_GEZ) dec.cond = CC_GEZ;
                    else                          dec.cond = CC_NEVER;
                end
                default: dec.kind = XF_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dslot_resolve.sv
module dslot_resolve
    import dslot_pkg::*;
#(
    parameter int INSN_BYTES = 4,
    parameter int REGION_W   = 4
) (
    input  xfer_dec_t           dec,
    input  logic [WORD_W-1:0]   pc,
    input  logic [WORD_W-1:0]   npc,
    input  logic [WORD_W-1:0]   instr,
    input  logic [WORD_W-1:0]   rs_val,
    input  logic [WORD_W-1:0]   rt_val,
    output logic                is_xfer,
    output logic                taken,
    output logic [WORD_W-1:0]   npc_next
);
    localparam logic [WORD_W-1:0] STEP    = WORD_W'(INSN_BYTES);
    localparam int                INDEX_W = WORD_W - REGION_W - 2;

    logic [WORD_W-1:0] seq_addr;
    logic [WORD_W-1:0] rel_addr;
    logic [WORD_W-1:0] region_addr;

    assign seq_addr    = npc + STEP;
    assign rel_addr    = pc + STEP + branch_offset(instr[15:0]);
    assign region_addr = {npc[WORD_W-1 -: REGION_W], instr[INDEX_W-1:0], 2'b00};

    assign is_xfer = (dec.kind != XF_NONE);

    always_comb begin
        taken    = 1'b0;
        npc_next = seq_addr;
        case (dec.kind)
            XF_BRANCH: begin
                taken    = cond_met(dec.cond, rs_val, rt_val);
                npc_next = taken ? rel_addr : seq_addr;
            end
            XF_REGION: begin
                taken    = 1'b1;
                npc_next = region_addr;
            end
            XF_REG: begin
                taken    = 1'b1;
                npc_next = rs_val;
            end
            default: begin
                taken    = 1'b0;
                npc_next = seq_addr;
            end
        endcase
    end
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dslot_pkg::*;
#(
    parameter logic [31:0] RESET_PC   = 32'h0,
    parameter int          INSN_BYTES = 4,
    parameter int          LINK_REG   = 31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step_valid,
    input  logic                is_ctrl,
    input  logic [OPC_W-1:0]    opcode,
    input  logic [WORD_W-1:0]   instr,
    input  logic [WORD_W-1:0]   rs_val,
    input  logic [WORD_W-1:0]   rt_val,
    output logic [WORD_W-1:0]   pc_q,
    output logic [WORD_W-1:0]   npc_q,
    output logic                fault,
    output logic                link_we,
    output logic [REG_W-1:0]    link_idx,
    output logic [WORD_W-1:0]   link_val
);
    localparam logic [WORD_W-1:0] STEP      = WORD_W'(INSN_BYTES);
    localparam logic [WORD_W-1:0] LINK_SKIP = WORD_W'(2 * INSN_BYTES);

    xfer_dec_t         dec;
    logic              is_xfer;
    logic              taken;
    logic [WORD_W-1:0] npc_next;
    logic              in_slot;
    logic              accept;
    logic              slot_fault;

    dslot_decode #(
        .LINK_REG (LINK_REG)
    ) u_decode (
        .is_ctrl (is_ctrl),
        .opcode  (opcode),
        .instr   (instr),
        .dec     (dec)
    );

    dslot_resolve #(
        .INSN_BYTES (INSN_BYTES),
        .REGION_W   (4)
    ) u_resolve (
        .dec      (dec),
        .pc       (pc_q),
        .npc      (npc_q),
        .instr    (instr),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .is_xfer  (is_xfer),
        .taken    (taken),
        .npc_next (npc_next)
    );

    assign in_slot    = (npc_q != pc_q + STEP);
    assign accept     = step_valid && !fault;
    assign slot_fault = accept && is_xfer && in_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= RESET_PC;
            npc_q    <= RESET_PC + STEP;
            fault    <= 1'b0;
            link_we  <= 1'b0;
            link_idx <= '0;
            link_val <= '0;
        end else begin
            link_we <= 1'b0;
            if (slot_fault) begin
                fault <= 1'b1;
            end else if (accept) begin
                pc_q  <= npc_q;
                npc_q <= npc_next;
                if (dec.link && (dec.link_idx != '0)) begin
                    link_we  <= 1'b1;
                    link_idx <= dec.link_idx;
                    link_val <= pc_q + LINK_SKIP;
                end
            end
        end
    end
endmodule

// File: rtl/dslot_pc_seq_chk.sv
module dslot_pc_seq_chk
    import dslot_pkg::*;
#(
    parameter int INSN_BYTES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                step_valid,
    input logic [WORD_W-1:0]   pc_q,
    input logic [WORD_W-1:0]   npc_q,
    input logic                fault,
    input logic                link_we,
    input logic [REG_W-1:0]    link_idx,
    input logic [WORD_W-1:0]   link_val
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(INSN_BYTES);

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault); // R12

    AST_FROZEN_AFTER_FAULT: assert property (@(posedge clk) disable iff (rst)
        fault |=> ($stable(pc_q) && $stable(npc_q) && !link_we)); // R12

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> ($stable(pc_q) && $stable(npc_q) && !link_we)); // R2

    AST_PC_FROM_NPC: assert property (@(posedge clk) disable iff (rst)
        (step_valid && !fault) |=> (fault || pc_q == $past(npc_q))); // R4

    AST_FAULT_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> ($stable(pc_q) && $stable(npc_q) && !link_we)); // R11

    AST_LINK_NONZERO: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_idx != '0)); // R10

    AST_LINK_RETURN: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_val == pc_q + STEP)); // R9
endmodule

bind dslot_pc_seq dslot_pc_seq_chk #(
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .pc_q       (pc_q),
    .npc_q      (npc_q),
    .fault      (fault),
    .link_we    (link_we),
    .link_idx   (link_idx),
    .link_val   (link_val)
);

// File: tb/dslot_pc_seq_bench.sv
`timescale 1ns/1ps
module dslot_pc_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        step_valid;
    logic        is_ctrl;
    logic [5:0]  opcode;
    logic [31:0] instr, rs_val, rt_val;
    logic [31:0] pc_q, npc_q, link_val;
    logic        fault, link_we;
    logic [4:0]  link_idx;

    always #10 clk = ~clk;

    dslot_pc_seq u_dslot_pc_seq (
        .clk(clk), .rst(rst), .step_valid(step_valid), .is_ctrl(is_ctrl),
        .opcode(opcode), .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
        .pc_q(pc_q), .npc_q(npc_q), .fault(fault), .link_we(link_we),
        .link_idx(link_idx), .link_val(link_val)
    );

    typedef struct {
        logic [31:0] pc, npc, lval;
        logic        flt, lwe;
        logic [4:0]  lidx;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] m_pc, m_npc, m_lval;
    logic        m_flt;
    logic [4:0]  m_lidx;

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rtf,
                                       input logic [15:0] low);
        return {op, 5'd0, rtf, low};
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 32'h0; m_npc = 32'h4; m_flt = 1'b0; m_lidx = 5'd0; m_lval = 32'h0;
    endtask

    task automatic step(input logic v, input logic c, input logic [5:0] op,
                        input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input string req);
        exp_t        e;
        logic        xf, tk, lk;
        logic [4:0]  li;
        logic [31:0] tgt;
        @(negedge clk);
        step_valid = v; is_ctrl = c; opcode = op; instr = ins; rs_val = a; rt_val = b;
        e.lwe = 1'b0;
        if (v && !m_flt) begin
            xf = 1'b0; tk = 1'b0; lk = 1'b0; li = 5'd0; tgt = 32'h0;
            if (c) begin
                if (op == 6'd2 || op == 6'd3) begin
                    xf = 1'b1; tk = 1'b1;
                    tgt = {m_npc[31:28], ins[25:0], 2'b00};
                    if (op == 6'd3) begin lk = 1'b1; li = 5'd31; end
                end else if (op == 6'd0 && (ins[5:0] == 6'd8 || ins[5:0] == 6'd9)) begin
                    xf = 1'b1; tk = 1'b1; tgt = a;
                    if (ins[5:0] == 6'd9) begin lk = 1'b1; li = ins[15:11]; end
                end else if (op == 6'd1 || (op >= 6'd4 && op <= 6'd7)) begin
                    xf = 1'b1;
                    case (op)
                        6'd4: tk = (a == b);
                        6'd5: tk = (a != b);
                        6'd6: tk = ($signed(a) <= 0);
                        6'd7: tk = ($signed(a) > 0);
                        default: tk = (ins[20:16] == 5'd0) ? ($signed(a) < 0) :
                                      (ins[20:16] == 5'd1) ? ($signed(a) >= 0) : 1'b0;
                    endcase
                    tgt = m_pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
                end
            end
            if (xf && m_npc != m_pc + 32'd4) begin
                m_flt = 1'b1;
            end else begin
                if (lk && li != 5'd0) begin
                    e.lwe = 1'b1; m_lidx = li; m_lval = m_pc + 32'd8;
                end
                m_pc  = m_npc;
                m_npc = (xf && tk) ? tgt : m_npc + 32'd4;
            end
        end
        e.pc = m_pc; e.npc = m_npc; e.flt = m_flt; e.lidx = m_lidx; e.lval = m_lval;
        e.req = req;
        @(posedge clk);
        #1;
        sb.push_back(e);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, 6'd0, 32'h0, 32'h0, 32'h0, req);
    endtask

    task automatic seq(input string req);
        step(1'b1, 1'b0, 6'd0, 32'h0, 32'h0, 32'h0, req);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                e = sb.pop_front();
                cmp(e.req, "pc_q", pc_q, e.pc);
                cmp(e.req, "npc_q", npc_q, e.npc);
                cmp(e.req, "fault", {31'd0, fault}, {31'd0, e.flt});
                cmp(e.req, "link_we", {31'd0, link_we}, {31'd0, e.lwe});
                if (e.lwe) begin
                    cmp(e.req, "link_idx", {27'd0, link_idx}, {27'd0, e.lidx});
                    cmp(e.req, "link_val", link_val, e.lval);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; step_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        cmp("R1", "pc_q", pc_q, 32'h0);
        cmp("R1", "npc_q", npc_q, 32'h4);
        cmp("R1", "fault", {31'd0, fault}, 32'd0);
        cmp("R1", "link_we", {31'd0, link_we}, 32'd0);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        rst = 1'b1; step_valid = 1'b0; is_ctrl = 1'b0; opcode = '0;
        instr = '0; rs_val = '0; rt_val = '0;
        model_reset();
        do_reset();
        idle("R2");
        seq("R3");
        seq("R3");
        // R5 R6: beq taken forward, then delay slot runs (R4)
        step(1, 1, 6'd4, mk(6'd4, 5'd0, 16'h0010), 32'd5, 32'd5, "R6");
        seq("R4");
        step(1, 1, 6'd5, mk(6'd5, 5'd0, 16'h0010), 32'd7, 32'd7, "R5");
        step(1, 1, 6'd5, mk(6'd5, 5'd0, 16'h0004), 32'd7, 32'd8, "R5");
        seq("R4");
        // R6 backward offset
        step(1, 1, 6'd6, mk(6'd6, 5'd0, 16'hFFFF), 32'd0, 32'd0, "R6");
        seq("R4");
        step(1, 1, 6'd6, mk(6'd6, 5'd0, 16'h0008), 32'd1, 32'd0, "R5");
        step(1, 1, 6'd7, mk(6'd7, 5'd0, 16'h0008), 32'hFFFF_FFFF, 32'd0, "R5");
        step(1, 1, 6'd7, mk(6'd7, 5'd0, 16'h0008), 32'd1, 32'd0, "R5");
        seq("R4");
        step(1, 1, 6'd1, mk(6'd1, 5'd0, 16'hFFF0), 32'hFFFF_FFFB, 32'd0, "R5");
        seq("R4");
        step(1, 1, 6'd1, mk(6'd1, 5'd1, 16'h0020), 32'hFFFF_FFFB, 32'd0, "R5");
        step(1, 1, 6'd1, mk(6'd1, 5'd1, 16'h0020), 32'd0, 32'd0, "R5");
        seq("R4");
        step(1, 1, 6'd1, mk(6'd1, 5'd2, 16'h0020), 32'd0, 32'd0, "R5");
        // R7 region jumps, R9 link for jal
        step(1, 1, 6'd2, {6'd2, 26'h000_0100}, 32'd0, 32'd0, "R7");
        seq("R4");
        step(1, 1, 6'd3, {6'd3, 26'h3FF_FFC0}, 32'd0, 32'd0, "R9");
        seq("R7");
        // R8 register jumps
        step(1, 1, 6'd0, mk(6'd0, 5'd0, 16'h0008), 32'h0000_2000, 32'd0, "R8");
        seq("R8");
        step(1, 1, 6'd0, mk(6'd0, 5'd0, {5'd7, 5'd0, 6'd9}), 32'h8000_3000, 32'd0, "R9");
        seq("R8");
        step(1, 1, 6'd0, mk(6'd0, 5'd0, {5'd0, 5'd0, 6'd9}), 32'h0000_0400, 32'd0, "R10");
        seq("R10");
        // R13 non-control encodings and is_ctrl low
        step(1, 1, 6'd8, mk(6'd8, 5'd0, 16'h0010), 32'd3, 32'd3, "R13");
        step(1, 1, 6'd0, mk(6'd0, 5'd0, 16'h0021), 32'd3, 32'd3, "R13");
        step(1, 0, 6'd2, {6'd2, 26'h000_0040}, 32'd0, 32'd0, "R13");
        step(1, 0, 6'd4, mk(6'd4, 5'd0, 16'h0040), 32'd3, 32'd3, "R13");
        idle("R2");
        // R11 control transfer inside a delay slot
        step(1, 1, 6'd4, mk(6'd4, 5'd0, 16'h0040), 32'd1, 32'd1, "R4");
        step(1, 1, 6'd3, {6'd3, 26'h000_0200}, 32'd0, 32'd0, "R11");
        // R12 frozen afterwards
        seq("R12");
        step(1, 1, 6'd3, {6'd3, 26'h000_0200}, 32'd0, 32'd0, "R12");
        idle("R12");
        @(posedge clk); #3;
        do_reset();
        seq("R3");
        idle("R2");
        @(posedge clk); #3;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule